// File: doc/BRIEF.md
# Match-Compare Event Timer Pair

A register-mapped timer with two channels, one for each processor, that run independently. Each channel has a 32-bit up-counter, a control word and a compare value. The counter advances on ticks of an optional power-of-two prescaler driven by the bus clock. On the tick that brings the counter to the compare value, the channel's bit in a shared status register is latched. The bit stays set until software writes a one to it. Each channel drives its own interrupt line, which is the latched status bit gated by that channel's interrupt-enable bit.

Software uses a channel as a one-shot event source. It stops the channel, preloads the counter (usually with zero), writes the distance to the next event as the compare value, and then sets count-enable and interrupt-enable. When the interrupt arrives, the handler clears the status bit and stops or reprograms the channel. The register port is a plain single-cycle bus: byte address, write strobe, write data, and combinational read data.

Top module: `cmp_timer_pair`

## Requirements
- R1: After a synchronous active-low reset, every control, compare, counter and status register reads zero and both interrupt outputs are low.
- R2: Register offsets for channel n (n = 0, 1) are: control at 0x00 + 4n, compare at 0x18 + 4n, counter at 0x48 + 4n. The status register is at 0x60. Reads of any other offset return zero.
- R3: In the control word, bit 0 is count-enable, bit 1 is interrupt-enable, bit 2 is a spare flag that only reads back, and bits [6:4] are the prescale select. Bits 3 and 7 through 31 are not stored and read as zero.
- R4: While count-enable is set, the counter rises by exactly one per prescaled tick. While count-enable is clear, the counter holds its value.
- R5: With prescale select s, a tick occurs every 2^s clock cycles. The first increment comes 2^s cycles after the clock edge that sets count-enable. s = 0 ticks every cycle.
- R6: A bus write to the counter register loads the written value at that clock edge, even while the channel is running. The load takes priority over the increment.
- R7: The counter wraps from 0xFFFFFFFF to 0 on a tick.
- R8: A channel's status bit sets at the clock edge where its counter advances onto the compare value. This works for every compare value, including 2 and 0xFFFFFFFE. Loading the counter with the compare value does not set the bit.
- R9: A status bit, once set, stays set until a write to 0x60 has a one in bit n. Zero bits in that write have no effect, and writing 0xFFFF clears every bit. If a set and a clear arrive in the same cycle, the set wins.
- R10: Interrupt output n is high exactly when status bit n is set and channel n's interrupt-enable bit is set.
- R11: The two channels are independent. Writing or running one channel does not change the other channel's counter or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, which is also the counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
The compare path is exercised with a compare of 5 from a preload of zero, which pins the exact tick on which the status bit appears. It is also tried with the extreme compares 2 and 0xFFFFFFFE, and with a preload placed just below the wrap point, which separates a correct modulo-2^32 counter from one that saturates or misses the match. A divide-by-four run shows whether the first increment arrives on the fourth edge rather than earlier or later. A counter load equal to the compare value checks that only an advance, never a load, raises an event. The clear writes use zero data, a single bit and 0xFFFF, and the interrupt-enable bit is toggled while status is held. Together these tell the sticky status latch apart from the interrupt gating.

// File: rtl/cmp_timer_pkg.sv
// Package cmp_timer_pkg
// Shared constants for the compare-event timer pair: bus widths, the
// register offsets and the control word field layout.
// Assumes at most six channels, the number of 4-byte slots below the
// compare block at 0x18.
package cmp_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int CTRL_W   = 7;
    localparam int PSEL_W   = 3;
    localparam int PSEL_LSB = 4;

    localparam logic [ADDR_W-1:0] CTRL_BASE  = 8'h00;
    localparam logic [ADDR_W-1:0] MATCH_BASE = 8'h18;
    localparam logic [ADDR_W-1:0] COUNT_BASE = 8'h48;
    localparam logic [ADDR_W-1:0] STS_ADDR   = 8'h60;

    localparam int CB_RUN   = 0;
    localparam int CB_IEN   = 1;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 7'h77;

    // Byte offset of a per-channel register.
    function automatic logic [ADDR_W-1:0] slot(logic [ADDR_W-1:0] base, int idx);
        return base + ADDR_W'(4 * idx);
    endfunction
endpackage

// File: rtl/cmp_timer_presc.sv
// Module cmp_timer_presc
// Power-of-two tick generator for one channel. With select s it gives one
// tick every 2^s cycles while enabled. The phase counter restarts from zero
// whenever the channel is disabled.
// Assumes PSEL_W is small: the phase counter is 2^PSEL_W - 1 bits wide.
module cmp_timer_presc #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);
    localparam int PH_W = (1 << PSEL_W) - 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] mask;

    // Low sel bits of the phase counter that must all be one for a tick.
    always_comb begin
        mask = ~({PH_W{1'b1}} << sel);
        tick = en && ((phase_q & mask) == mask);
    end

    // Phase counter runs while enabled and restarts when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) phase_q <= '0;
        else               phase_q <= phase_q + 1'b1;
    end

    // R5
    // With a nonzero select, ticks never come on consecutive cycles.
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != '0 && tick) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/cmp_timer_chan.sv
// Module cmp_timer_chan
// One timer channel: the control, compare and counter registers, the
// prescaler, and detection of a compare hit. The hit is a single-cycle
// pulse in the cycle whose tick moves the counter onto the compare value.
// Assumes the bus decode in the parent produces one-hot write strobes.
module cmp_timer_chan
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              match_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] match_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              hit
);
    logic              run;
    logic              tick;
    logic [DATA_W-1:0] cnt_nxt;

    assign run     = ctrl_q[CB_RUN];
    assign cnt_nxt = cnt_q + 1'b1;

    cmp_timer_presc #(.PSEL_W(PSEL_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run),
        .sel  (ctrl_q[PSEL_LSB +: PSEL_W]),
        .tick (tick)
    );

    // Control and compare registers, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            match_q <= '0;
        end else begin
            if (ctrl_we)  ctrl_q  <= wdata[CTRL_W-1:0] & CTRL_MASK;
            if (match_we) match_q <= wdata;
        end
    end

    // Counter: a bus load wins, otherwise it steps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (cnt_we)     cnt_q <= wdata;
        else if (run && tick) cnt_q <= cnt_nxt;
    end

    // Hit when a tick moves the counter onto the compare value.
    assign hit = run && tick && !cnt_we && (cnt_nxt == match_q);

    // R4
    // The counter holds while stopped and not loaded.
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt_q));

    // R7
    // A tick steps the counter by one modulo 2^32.
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !cnt_we) |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));

    // R6
    // A load takes effect on the next edge.
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/cmp_timer_pair.sv
// Module cmp_timer_pair
// Top level of the two-channel compare-event timer: the register decode,
// read-back mux, shared write-one-to-clear status register and interrupt
// gating. Each channel is an instance of cmp_timer_chan.
// Assumes a single-cycle bus with combinational read data and NCH <= 6.
module cmp_timer_pair
    import cmp_timer_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    logic [CTRL_W-1:0] ctrl_q  [NCH];
    logic [DATA_W-1:0] match_q [NCH];
    logic [DATA_W-1:0] cnt_q   [NCH];
    logic [NCH-1:0]    hit;
    logic [NCH-1:0]    sts_q;
    logic [NCH-1:0]    sts_clr;
    logic              sts_we;

    assign sts_we  = bus_we && (bus_addr == STS_ADDR);
    assign sts_clr = sts_we ? bus_wdata[NCH-1:0] : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmp_timer_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (bus_we && bus_addr == slot(CTRL_BASE, i)),
            .match_we(bus_we && bus_addr == slot(MATCH_BASE, i)),
            .cnt_we  (bus_we && bus_addr == slot(COUNT_BASE, i)),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_q[i]),
            .match_q (match_q[i]),
            .cnt_q   (cnt_q[i]),
            .hit     (hit[i])
        );

        // Interrupt line: latched status gated by interrupt-enable.
        assign irq[i] = sts_q[i] & ctrl_q[i][CB_IEN];

        // R9
        // A set status bit survives any cycle without a clear for it.
        sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !sts_clr[i]) |=> sts_q[i]);

        // R9
        // A clear with no simultaneous hit empties the bit.
        sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_clr[i] && !hit[i]) |=> !sts_q[i]);

        // R8
        // A hit always leaves the status bit set.
        sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> sts_q[i]);
    end

    // Status latch: a hit sets a bit and a one written to 0x60 clears it; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | hit;
    end

    // Read-back mux over all mapped registers; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STS_ADDR) bus_rdata = DATA_W'(sts_q);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == slot(CTRL_BASE, i))  bus_rdata = DATA_W'(ctrl_q[i]);
            if (bus_addr == slot(MATCH_BASE, i)) bus_rdata = match_q[i];
            if (bus_addr == slot(COUNT_BASE, i)) bus_rdata = cnt_q[i];
        end
    end

    // R1
    // Nothing is pending in the first cycle after reset.
    rst_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (sts_q == '0 && irq == '0));
endmodule

// File: tb/cmp_timer_pair_tb.sv
// Directed bench for cmp_timer_pair: one task for each scenario, and each
// task checks its own results through the register port and irq.
module cmp_timer_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int errors = 0;
    int checks = 0;

    localparam logic [7:0] C0 = 8'h00, C1 = 8'h04, M0 = 8'h18, M1 = 8'h1C;
    localparam logic [7:0] N0 = 8'h48, N1 = 8'h4C, ST = 8'h60;

    always #4 clk = ~clk;

    cmp_timer_pair u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Write at the next rising edge; returns 1 ns after that edge.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl0", C0, 0);   rd_chk("R1 ctrl1", C1, 0);
        rd_chk("R1 match0", M0, 0);  rd_chk("R1 match1", M1, 0);
        rd_chk("R1 cnt0", N0, 0);    rd_chk("R1 cnt1", N1, 0);
        rd_chk("R1 status", ST, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_map_ctrl;
        wr(C0, 32'hFFFF_FFF4);
        rd_chk("R3 ctrl readback", C0, 32'h74);
        rd_chk("R2 unmapped 0x08", 8'h08, 0);
        rd_chk("R2 unmapped 0x64", 8'h64, 0);
        edges(3);
        rd_chk("R3 no run without bit0", N0, 0);
        wr(C0, 0);
    endtask

    task automatic t_basic_match;
        wr(M0, 5); wr(N0, 0); wr(C0, 3);
        edges(4);
        rd_chk("R4 count after 4", N0, 4);
        rd_chk("R8 no early status", ST, 0);
        edges(1);
        rd_chk("R8 status at match", ST, 1);
        chk("R10 irq0 raised", 32'(irq), 1);
        wr(C0, 1);
        chk("R10 irq masked", 32'(irq), 0);
        rd_chk("R9 status held while masked", ST, 1);
        wr(ST, 0);
        rd_chk("R9 zero write no effect", ST, 1);
        wr(C0, 3);
        chk("R10 irq back on", 32'(irq), 1);
        wr(ST, 1);
        rd_chk("R9 w1c clears", ST, 0);
        chk("R10 irq drops", 32'(irq), 0);
        wr(C0, 0);
    endtask

    task automatic t_hold_load;
        logic [31:0] v;
        bus_addr = N0; #1 v = bus_rdata;
        edges(5);
        rd_chk("R4 holds while stopped", N0, v);
        wr(C0, 1);
        wr(N0, 32'h100);
        rd_chk("R6 load beats increment", N0, 32'h100);
        edges(2);
        rd_chk("R4 counts after load", N0, 32'h102);
        wr(C0, 0);
        wr(M0, 32'h10); wr(N0, 32'h10);
        edges(2);
        rd_chk("R8 load onto compare no event", ST, 0);
    endtask

    task automatic t_prescale;
        wr(N0, 0); wr(M0, 100);
        wr(C0, 32'h21);
        edges(3);
        rd_chk("R5 div4 before 4th edge", N0, 0);
        edges(1);
        rd_chk("R5 div4 first step", N0, 1);
        edges(4);
        rd_chk("R5 div4 second step", N0, 2);
        wr(C0, 0);
    endtask

    task automatic t_bounds;
        wr(N0, 0); wr(M0, 2); wr(C0, 1);
        edges(1);
        rd_chk("R8 compare 2 not yet", ST, 0);
        edges(1);
        rd_chk("R8 compare 2 hit", ST, 1);
        wr(C0, 0); wr(ST, 1);
        wr(N0, 32'hFFFF_FFFD); wr(M0, 32'hFFFF_FFFE); wr(C0, 1);
        edges(1);
        rd_chk("R8 compare FFFFFFFE hit", ST, 1);
        wr(C0, 0); wr(ST, 1);
        wr(N0, 32'hFFFF_FFFF); wr(C0, 1);
        edges(1);
        rd_chk("R7 wrap to zero", N0, 0);
        wr(C0, 0);
    endtask

    task automatic t_two_chan;
        logic [31:0] v;
        wr(ST, 32'hFFFF);
        bus_addr = N0; #1 v = bus_rdata;
        wr(N1, 0); wr(M1, 3); wr(C1, 3);
        edges(3);
        rd_chk("R11 ch1 status only", ST, 2);
        chk("R11 irq1 only", 32'(irq), 2);
        rd_chk("R11 ch0 counter untouched", N0, v);
        wr(N0, 0); wr(M0, 1); wr(C0, 1);
        edges(1);
        rd_chk("R9 both pending", ST, 3);
        wr(ST, 32'hFFFF);
        rd_chk("R9 FFFF clears all", ST, 0);
        wr(C0, 0); wr(C1, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_map_ctrl();
        t_basic_match();
        t_hold_load();
        t_prescale();
        t_bounds();
        t_two_chan();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule